// File: doc/BRIEF.md
# PCIe Configuration Address Translator

This block sits on the slave side of a root-port core. It turns accesses that land in a 64 KiB configuration window into configuration-request addresses for the core. The bus, device and function of the target are not taken from the access address. They come from two 16-bit selector registers, which software loads through a small register port. Bit 12 of the window offset picks one of the two selectors. Bits 15:12 of the offset pick the request type. The dword offset inside the 4 KiB region passes straight through as the configuration register address.

Each window access that hits produces exactly one registered request toward the core, one clock later. The request carries a 32-bit core address, a type 0 or type 1 flag, and the access's byte enables, write data and direction. Accesses outside the window are ignored. The window base is a parameter aligned to 64 KiB. Completion handling, retries and link state belong to other blocks.

Top module: `cfg_addr_xlat`

## Requirements
- R1: An access is claimed only when winValid is high and winAddr[ADDR_W-1:16] equals WIN_BASE[ADDR_W-1:16]. An unclaimed access raises no request; coreReqValid stays low in the following cycle.
- R2: A claimed access in cycle N raises coreReqValid for exactly cycle N+1, after the clock edge that ends cycle N. A cycle with no claimed access is followed by coreReqValid low.
- R3: coreReqType1 is 0 when window offset bits 15:12 are all zero. It is 1 for any other value of those bits.
- R4: coreAddr[31:16] equals selector 1 when offset bit 12 is 1, and selector 0 when it is 0. Each selector holds the bus number in bits 15:8 and the device/function in bits 7:0.
- R5: coreAddr[15:12] is zero, coreAddr[11:2] equals offset bits 11:2, and coreAddr[1:0] is zero. Offset bits 1:0 are dropped.
- R6: coreByteEn, coreWrData and coreReqWrite equal the winByteEn, winWrData and winWrite of the access that raised the request.
- R7: A register-port write to offset BDF_REG_OFF (default 0) updates the selectors byte by byte under regByteEn. Lane 0 (data 7:0) and lane 1 (data 15:8) go to selector 0 bits 7:0 and 15:8. Lanes 2 and 3 (data 23:16 and 31:24) go to selector 1 bits 7:0 and 15:8.
- R8: A register-port read of BDF_REG_OFF returns {selector 1, selector 0} on regRdData in the next cycle. A read of any other offset returns zero. A write to any other offset changes no selector.
- R9: Reset clears both selectors, regRdData and coreReqValid to zero.
- R10: A window access in the same cycle as a selector write uses the selector value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| winValid | input | 1 | Window-side access strobe, one cycle per access |
| winWrite | input | 1 | Access is a write |
| winAddr | input | ADDR_W | Access address |
| winByteEn | input | 4 | Access byte enables |
| winWrData | input | 32 | Access write data |
| regValid | input | 1 | Register-port access strobe |
| regWrite | input | 1 | Register-port access is a write |
| regAddr | input | REG_AW | Register-port byte offset |
| regByteEn | input | 4 | Register-port byte enables |
| regWrData | input | 32 | Register-port write data |
| regRdData | output | 32 | Register-port read data, valid the cycle after a read |
| coreReqValid | output | 1 | Configuration request toward the core |
| coreReqWrite | output | 1 | Request is a write |
| coreReqType1 | output | 1 | 1 for a type 1 request, 0 for type 0 |
| coreAddr | output | 32 | Assembled configuration address |
| coreByteEn | output | 4 | Forwarded byte enables |
| coreWrData | output | 32 | Forwarded write data |

## Verification
The bound checker watches the port-level translation on every cycle. It checks that a request follows exactly the claimed accesses, that the type flag matches the offset's upper nibble, that the low address field is a copy of the offset's dword index with zeroed padding, and that byte enables and data are forwarded unchanged. It also checks that reads of foreign register offsets return zero. The contents of the selectors are checked only by the bench's scenarios. These cover partial byte-enable writes, ignored writes to other offsets, choosing between the two selectors across the upper regions of the window, and a selector write that collides with a window access in the same cycle.

// File: rtl/cfg_xlat_pkg.sv
package cfg_xlat_pkg;

  localparam int LANES = 4;

  typedef struct packed {
    logic             reqLoad;   // claimed window access this cycle
    logic             reqWrite;  // direction of that access
    logic             reqType1;  // nonzero offset nibble
    logic             bdfSel;    // offset bit 12
    logic [LANES-1:0] laneWr;    // selector byte-lane write enables
    logic             rdLoad;    // register read this cycle
    logic             rdHit;     // read targets the selector offset
  } xlatStrobe_t;

endpackage

// File: rtl/cfg_xlat_ctrl.sv
module cfg_xlat_ctrl
  import cfg_xlat_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h3000_0000,
  parameter int                REG_AW      = 4,
  parameter logic [REG_AW-1:0] BDF_REG_OFF = '0
) (
  input  logic              winValid,
  input  logic              winWrite,
  input  logic [ADDR_W-1:12] winAddrHi,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [LANES-1:0]  regByteEn,
  output xlatStrobe_t       strobe
);

  localparam int WIN_AW = 16;

  logic winHit;
  logic regHit;

  assign winHit = winValid && (winAddrHi[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
  assign regHit = (regAddr == BDF_REG_OFF);

  always_comb begin
    strobe.reqLoad  = winHit;
    strobe.reqWrite = winWrite;
    strobe.reqType1 = |winAddrHi[WIN_AW-1:12];
    strobe.bdfSel   = winAddrHi[12];
    strobe.rdLoad   = regValid && !regWrite;
    strobe.rdHit    = regHit;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLaneDec
    assign strobe.laneWr[g] = regValid && regWrite && regHit && regByteEn[g];
  end

endmodule

// File: rtl/cfg_xlat_dp.sv
module cfg_xlat_dp
  import cfg_xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  xlatStrobe_t      strobe,
  input  logic [11:2]      winDwIdx,
  input  logic [LANES-1:0] winByteEn,
  input  logic [31:0]      winWrData,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic             coreReqValid,
  output logic             coreReqWrite,
  output logic             coreReqType1,
  output logic [31:0]      coreAddr,
  output logic [LANES-1:0] coreByteEn,
  output logic [31:0]      coreWrData
);

  logic [31:0] bdfPacked;   // {selector 1, selector 0}
  logic [15:0] bdfChosen;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [7:0] laneQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                laneQ <= '0;
      else if (strobe.laneWr[g]) laneQ <= regWrData[8*g +: 8];
    end
    assign bdfPacked[8*g +: 8] = laneQ;
  end

  assign bdfChosen = strobe.bdfSel ? bdfPacked[31:16] : bdfPacked[15:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreReqValid <= 1'b0;
      coreReqWrite <= 1'b0;
      coreReqType1 <= 1'b0;
      coreAddr     <= '0;
      coreByteEn   <= '0;
      coreWrData   <= '0;
    end else begin
      coreReqValid <= strobe.reqLoad;
      if (strobe.reqLoad) begin
        coreReqWrite <= strobe.reqWrite;
        coreReqType1 <= strobe.reqType1;
        coreAddr     <= {bdfChosen, 4'b0000, winDwIdx, 2'b00};
        coreByteEn   <= winByteEn;
        coreWrData   <= winWrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             regRdData <= '0;
    else if (strobe.rdLoad) regRdData <= strobe.rdHit ? bdfPacked : '0;
  end

endmodule

// File: rtl/cfg_addr_xlat.sv
module cfg_addr_xlat
  import cfg_xlat_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h3000_0000,
  parameter int                REG_AW      = 4,
  parameter logic [REG_AW-1:0] BDF_REG_OFF = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              winValid,
  input  logic              winWrite,
  input  logic [ADDR_W-1:0] winAddr,
  input  logic [3:0]        winByteEn,
  input  logic [31:0]       winWrData,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [3:0]        regByteEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              coreReqValid,
  output logic              coreReqWrite,
  output logic              coreReqType1,
  output logic [31:0]       coreAddr,
  output logic [3:0]        coreByteEn,
  output logic [31:0]       coreWrData
);

  xlatStrobe_t strobe;
  logic        unusedByteOfs;

  assign unusedByteOfs = ^winAddr[1:0];

  cfg_xlat_ctrl #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .REG_AW(REG_AW), .BDF_REG_OFF(BDF_REG_OFF)
  ) u_ctrl (
    .winValid (winValid),
    .winWrite (winWrite),
    .winAddrHi(winAddr[ADDR_W-1:12]),
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regByteEn(regByteEn),
    .strobe   (strobe)
  );

  cfg_xlat_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .winDwIdx    (winAddr[11:2]),
    .winByteEn   (winByteEn),
    .winWrData   (winWrData),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .coreReqValid(coreReqValid),
    .coreReqWrite(coreReqWrite),
    .coreReqType1(coreReqType1),
    .coreAddr    (coreAddr),
    .coreByteEn  (coreByteEn),
    .coreWrData  (coreWrData)
  );

endmodule

// File: rtl/cfg_xlat_chk.sv
module cfg_xlat_chk #(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h3000_0000,
  parameter int                REG_AW      = 4,
  parameter logic [REG_AW-1:0] BDF_REG_OFF = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              winValid,
  input logic              winWrite,
  input logic [ADDR_W-1:0] winAddr,
  input logic [3:0]        winByteEn,
  input logic [31:0]       winWrData,
  input logic              regValid,
  input logic              regWrite,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regRdData,
  input logic              coreReqValid,
  input logic              coreReqWrite,
  input logic              coreReqType1,
  input logic [31:0]       coreAddr,
  input logic [3:0]        coreByteEn,
  input logic [31:0]       coreWrData
);

  logic inWindow;
  assign inWindow = winValid && (winAddr[ADDR_W-1:16] == WIN_BASE[ADDR_W-1:16]);

  AST_REQ_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rstN)
    coreReqValid |-> $past(inWindow)); // R1
  AST_REQ_AFTER_HIT: assert property (@(posedge clk) disable iff (!rstN)
    inWindow |=> coreReqValid); // R2
  AST_TYPE_FROM_NIBBLE: assert property (@(posedge clk) disable iff (!rstN)
    inWindow |=> (coreReqType1 == $past(winAddr[15:12] != 4'h0))); // R3
  AST_LOW_ADDR_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    inWindow |=> (coreAddr[15:0] == {4'h0, $past(winAddr[11:2]), 2'b00})); // R5
  AST_FORWARD_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    inWindow |=> (coreByteEn == $past(winByteEn) && coreWrData == $past(winWrData)
                  && coreReqWrite == $past(winWrite))); // R6
  AST_FOREIGN_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && regAddr != BDF_REG_OFF) |=> (regRdData == 32'h0)); // R8

endmodule

bind cfg_addr_xlat cfg_xlat_chk #(
  .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .REG_AW(REG_AW), .BDF_REG_OFF(BDF_REG_OFF)
) u_chk (.*);

// File: tb/tb_cfg_addr_xlat.sv
module tb_cfg_addr_xlat;

  localparam logic [31:0] BASE = 32'h3000_0000;
  localparam time HALF = 2.5ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        winValid = 1'b0, winWrite = 1'b0;
  logic [31:0] winAddr = '0;
  logic [3:0]  winByteEn = '0;
  logic [31:0] winWrData = '0;
  logic        regValid = 1'b0, regWrite = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        coreReqValid, coreReqWrite, coreReqType1;
  logic [31:0] coreAddr;
  logic [3:0]  coreByteEn;
  logic [31:0] coreWrData;

  int checks = 0;
  int errors = 0;
  logic [15:0] sel0 = '0, sel1 = '0;   // bench model of the selectors

  always #HALF clk = ~clk;

  cfg_addr_xlat #(.WIN_BASE(BASE)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic regWr(logic [3:0] a, logic [3:0] be, logic [31:0] d);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regByteEn = be; regWrData = d;
    step();
    regValid = 1'b0; regWrite = 1'b0;
    if (a == 4'h0) begin
      if (be[0]) sel0[7:0]  = d[7:0];
      if (be[1]) sel0[15:8] = d[15:8];
      if (be[2]) sel1[7:0]  = d[23:16];
      if (be[3]) sel1[15:8] = d[31:24];
    end
  endtask

  task automatic regRdCheck(string req, logic [3:0] a);
    regValid = 1'b1; regWrite = 1'b0; regAddr = a;
    step();
    regValid = 1'b0;
    check(req, regRdData, (a == 4'h0) ? {sel1, sel0} : 32'h0);
  endtask

  task automatic winCheck(logic [31:0] addr, logic wr, logic [3:0] be, logic [31:0] d);
    logic [15:0] ofs;
    ofs = addr[15:0];
    winValid = 1'b1; winWrite = wr; winAddr = addr; winByteEn = be; winWrData = d;
    step();
    winValid = 1'b0;
    check("R2 valid after hit", {31'h0, coreReqValid}, 32'h1);
    check("R3 type", {31'h0, coreReqType1}, {31'h0, ofs[15:12] != 4'h0});
    check("R4 selector in addr[31:16]", {16'h0, coreAddr[31:16]}, {16'h0, ofs[12] ? sel1 : sel0});
    check("R5 low address field", {16'h0, coreAddr[15:0]}, {16'h0, 4'h0, ofs[11:2], 2'b00});
    check("R6 byte enables", {28'h0, coreByteEn}, {28'h0, be});
    check("R6 write data", coreWrData, d);
    check("R6 direction", {31'h0, coreReqWrite}, {31'h0, wr});
  endtask

  task automatic testReset();
    check("R9 no request in reset", {31'h0, coreReqValid}, 32'h0);
    regRdCheck("R9 selectors cleared", 4'h0);
  endtask

  task automatic testRegPort();
    regWr(4'h0, 4'hF, 32'hBBBB_AAAA);
    regRdCheck("R7 full write readback", 4'h0);
    check("R7 packing", {sel1, sel0}, 32'hBBBB_AAAA);
    regWr(4'h0, 4'b0100, 32'h11CC_2233);
    regRdCheck("R7 single lane write", 4'h0);
    check("R7 lane 2 only", {sel1, sel0}, 32'hBBCC_AAAA);
    regWr(4'h4, 4'hF, 32'hDEAD_BEEF);
    regRdCheck("R8 foreign write ignored", 4'h0);
    regRdCheck("R8 foreign read zero", 4'h4);
  endtask

  task automatic testType0();
    regWr(4'h0, 4'hF, 32'h0318_0100);
    winCheck(BASE + 32'h0000_0004, 1'b0, 4'hF, 32'h0);
    winCheck(BASE + 32'h0000_0FFF, 1'b1, 4'b0011, 32'h1234_5678);
  endtask

  task automatic testType1();
    winCheck(BASE + 32'h0000_1FFC, 1'b1, 4'b1000, 32'hCAFE_F00D);
    winCheck(BASE + 32'h0000_2ABC, 1'b0, 4'hF, 32'h0);
    winCheck(BASE + 32'h0000_F3FF, 1'b0, 4'b0110, 32'h0);
  endtask

  task automatic testOutside();
    winValid = 1'b1; winAddr = BASE - 32'h4; winByteEn = 4'hF;
    step();
    check("R1 below window", {31'h0, coreReqValid}, 32'h0);
    winAddr = BASE + 32'h0001_0000;
    step();
    check("R1 above window", {31'h0, coreReqValid}, 32'h0);
    winValid = 1'b0;
  endtask

  task automatic testSingle();
    winCheck(BASE + 32'h0000_0010, 1'b0, 4'hF, 32'h0);
    step();
    check("R2 one request per access", {31'h0, coreReqValid}, 32'h0);
  endtask

  task automatic testCollision();
    logic [15:0] oldSel0;
    oldSel0 = sel0;
    regValid = 1'b1; regWrite = 1'b1; regAddr = 4'h0; regByteEn = 4'b0011; regWrData = 32'h0000_5A5A;
    winValid = 1'b1; winWrite = 1'b0; winAddr = BASE + 32'h0000_0008; winByteEn = 4'hF;
    step();
    regValid = 1'b0; regWrite = 1'b0; winValid = 1'b0;
    check("R10 old selector used", {16'h0, coreAddr[31:16]}, {16'h0, oldSel0});
    sel0 = 16'h5A5A;
    winCheck(BASE + 32'h0000_0008, 1'b0, 4'hF, 32'h0);
    check("R10 new selector afterwards", {16'h0, coreAddr[31:16]}, 32'h0000_5A5A);
  endtask

  initial begin
    #1;
    step(); step();
    testReset();
    rstN = 1'b1;
    step();
    testReset();
    testRegPort();
    testType0();
    testType1();
    testOutside();
    testSingle();
    testCollision();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(HALF * 2 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule